// File: doc/BRIEF.md
# Programmable Horizontal Line Phase Sequencer

This block walks an LCD line through its horizontal phases. A 12-bit pixel counter climbs from zero on every line. Eight programmed compare values, P1 to P8, are checked against it. A compare value is an absolute count, so its match is an event at one exact pixel position. A match moves the block into the phase that belongs to that compare value. The block drives hsync while in the sync phase. It raises a pixel-fetch enable during the image phase. It selects the solid border colour in the border phases on both sides of the image. It also pulses a line-wrap strobe each time the counter goes back to zero.

Software reaches the compare values and one configuration word through a 32-bit register port, with one write strobe and a read path that returns data one cycle after the address. The configuration word holds the run enable, a pixel format code and a fetch burst-size code. The block keeps a shadow copy of these settings and loads it only when the counter is at zero. A write made in the middle of a line therefore changes nothing until the next line starts.

Top module: `htiming_seq`

## Requirements
- R1: After reset the phase is blanking (code 6), hcount is 0, hsync, fetch_en, border_sel and line_wrap are low, and every register reads back 0.
- R2: While the enable bit is set, hcount rises by one each clock. With P8 set to 0 it wraps from 4095 to 0. While the enable bit is clear, hcount is held at 0 and the phase is held at blanking.
- R3: Register map. Offset 0x04 holds P1 in bits 11:0 and P2 in bits 27:16. Offset 0x08 holds P3 and P4 in the same layout, 0x0C holds P5 and P6, and 0x10 holds P7 and P8. Bits 15:12 and 31:28 of these registers read as 0. Read data appears one cycle after the address.
- R4: When hcount equals Pi (i = 1..7), the phase takes the code for i from the next cycle on. The codes are: P1 gives sync 0, P2 back porch 1, P3 left border 2, P4 image 3, P5 right border 4, P6 front porch 5, P7 blanking 6.
- R5: If several compare values match the same count, only the one with the highest index acts. A winning P8 leaves the phase as it was.
- R6: A nonzero P8 that matches hcount makes hcount 0 on the next cycle. The phase does not change at that point.
- R7: hsync is high only in phase 0, fetch_en only in phase 3, and border_sel only in phases 2 and 4. All three change in the same cycle as phase.
- R8: line_wrap is high for one cycle in every enabled cycle in which hcount has just returned to 0, whether through a P8 match or through the natural wrap.
- R9: Writes to compare values, format or burst size affect matching and the outputs only from the next cycle in which hcount is 0.
- R10: Offset 0x00 is the configuration word. Bits 2:0 hold the format, bits 9:8 the burst code and bit 16 the enable. All other bits read as 0. The enable acts on the cycle after the write.
- R11: burst_bytes reports 64 for burst code 0, 128 for code 1, and 256 for codes 2 and 3. pix_format gives the shadowed format code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| hcount | output | 12 | Current pixel count |
| phase | output | 3 | Current line phase code |
| hsync | output | 1 | High during the sync phase |
| fetch_en | output | 1 | High during the image phase |
| border_sel | output | 1 | High during the left and right border phases |
| line_wrap | output | 1 | One-cycle strobe when hcount returns to 0 |
| pix_format | output | 3 | Shadowed pixel format code |
| burst_bytes | output | 9 | Shadowed fetch burst size in bytes |

## Verification
The assertions assume that the address and write inputs are held steady for a whole clock and that only the defined offsets are written. The bench follows both rules: it changes inputs only on the falling edge and writes nothing but the five registers. The assertions on count stepping and line end also depend on the enable being a register inside the block, so they hold whatever order of writes the bench uses. Some stimulus is placed on purpose: writes land mid-line, compare values are set equal to each other, and P8 is cleared. These cases exercise the shadow load, the priority rule and the 4095 wrap, all while keeping to the same register discipline.

// File: rtl/htiming_pkg.sv
package htiming_pkg;

  typedef enum logic [2:0] {
    PH_SYNC    = 3'd0,
    PH_BACK    = 3'd1,
    PH_LBORDER = 3'd2,
    PH_IMAGE   = 3'd3,
    PH_RBORDER = 3'd4,
    PH_FRONT   = 3'd5,
    PH_BLANK   = 3'd6
  } phase_e;

  localparam int HALF_W = 16;

  function automatic logic [8:0] burst_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    burst_to_bytes = 9'd64;
      2'd1:    burst_to_bytes = 9'd128;
      default: burst_to_bytes = 9'd256;
    endcase
  endfunction

endpackage

// File: rtl/htiming_regs.sv
module htiming_regs
  import htiming_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int NUM_P  = 8,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  input  logic [CNT_W-1:0]             cnt,
  output logic [NUM_P-1:0][CNT_W-1:0]  eff,
  output logic                         run_en,
  output logic [2:0]                   fmt,
  output logic [1:0]                   burst
);

  localparam int NUM_PAIR = NUM_P / 2;
  localparam int PAD_W    = HALF_W - CNT_W;

  logic [NUM_P-1:0][CNT_W-1:0] live_q, shadow_q;
  logic [2:0]  fmt_q, sh_fmt_q;
  logic [1:0]  burst_q, sh_burst_q;
  logic        en_q;
  logic [31:0] rd_mux, rdata_q;
  logic        line_top;
  logic        unused_wbits;

  assign line_top     = (cnt == '0);
  assign unused_wbits = ^{wdata[HALF_W-1:CNT_W], wdata[31:HALF_W+CNT_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      fmt_q   <= '0;
      burst_q <= '0;
      en_q    <= 1'b0;
    end else if (we) begin
      if (addr == '0) begin
        fmt_q   <= wdata[2:0];
        burst_q <= wdata[9:8];
        en_q    <= wdata[16];
      end
      for (int k = 0; k < NUM_PAIR; k++) begin
        if (addr == ADDR_W'((k + 1) * 4)) begin
          live_q[2*k]   <= wdata[CNT_W-1:0];
          live_q[2*k+1] <= wdata[HALF_W+CNT_W-1:HALF_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q   <= '0;
      sh_fmt_q   <= '0;
      sh_burst_q <= '0;
    end else if (line_top) begin
      shadow_q   <= live_q;
      sh_fmt_q   <= fmt_q;
      sh_burst_q <= burst_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == '0) rd_mux = {15'd0, en_q, 6'd0, burst_q, 5'd0, fmt_q};
    for (int k = 0; k < NUM_PAIR; k++) begin
      if (addr == ADDR_W'((k + 1) * 4))
        rd_mux = {{PAD_W{1'b0}}, live_q[2*k+1], {PAD_W{1'b0}}, live_q[2*k]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata  = rdata_q;
  assign eff    = line_top ? live_q : shadow_q;
  assign run_en = en_q;
  assign fmt    = sh_fmt_q;
  assign burst  = sh_burst_q;

  // R3: padding bits above each 12-bit half never read as one
  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rdata[15:12] == 4'd0) && (rdata[31:28] == 4'd0));

  // R9: shadow copy stays frozen while the line is under way
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !line_top |=> $stable(shadow_q));

endmodule

// File: rtl/htiming_match.sv
module htiming_match #(
  parameter int CNT_W = 12,
  parameter int NUM_P = 8,
  parameter int IDX_W = $clog2(NUM_P)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [NUM_P-1:0][CNT_W-1:0] eff,
  output logic                        ph_valid,
  output logic [IDX_W-1:0]            ph_idx,
  output logic                        line_end
);

  logic [NUM_P-1:0] hit;
  logic [NUM_P-1:0] win;

  generate
    for (genvar i = 0; i < NUM_P; i++) begin : g_cmp
      if (i == NUM_P - 1) begin : g_last
        assign hit[i] = (eff[i] == cnt) && (eff[i] != '0);
      end else begin : g_mid
        assign hit[i] = (eff[i] == cnt);
      end
    end
  endgenerate

  always_comb begin
    win = '0;
    for (int i = 0; i < NUM_P; i++) begin
      if (hit[i]) begin
        win    = '0;
        win[i] = 1'b1;
      end
    end
  end

  always_comb begin
    ph_valid = 1'b0;
    ph_idx   = '0;
    for (int i = 0; i < NUM_P - 1; i++) begin
      if (win[i]) begin
        ph_valid = 1'b1;
        ph_idx   = IDX_W'(i);
      end
    end
  end

  assign line_end = win[NUM_P-1];

  // R5: at most one compare value acts per count
  assert_single_winner_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win));

  // R5: a winning line end never coexists with a phase change
  assert_end_beats_phase_R5: assert property (@(posedge clk) disable iff (rst)
    line_end |-> !ph_valid);

endmodule

// File: rtl/htiming_phase.sv
module htiming_phase
  import htiming_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             ph_valid,
  input  logic [IDX_W-1:0] ph_idx,
  input  logic             line_end,
  output logic [CNT_W-1:0] cnt,
  output phase_e           phase,
  output logic             hsync,
  output logic             fetch_en,
  output logic             border_sel,
  output logic             line_wrap
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  phase_e           phase_q, phase_d;
  logic             hsync_q, fetch_q, border_q, wrap_q;

  always_comb begin
    cnt_d   = line_end ? '0 : cnt_q + CNT_W'(1);
    phase_d = ph_valid ? phase_e'(ph_idx) : phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      cnt_q    <= '0;
      phase_q  <= PH_BLANK;
      hsync_q  <= 1'b0;
      fetch_q  <= 1'b0;
      border_q <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      phase_q  <= phase_d;
      hsync_q  <= (phase_d == PH_SYNC);
      fetch_q  <= (phase_d == PH_IMAGE);
      border_q <= (phase_d == PH_LBORDER) || (phase_d == PH_RBORDER);
      wrap_q   <= (cnt_d == '0);
    end
  end

  assign cnt        = cnt_q;
  assign phase      = phase_q;
  assign hsync      = hsync_q;
  assign fetch_en   = fetch_q;
  assign border_sel = border_q;
  assign line_wrap  = wrap_q;

  // R2: idle holds the counter and the blanking phase
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (cnt_q == '0) && (phase_q == PH_BLANK));

  // R2: the counter steps by one unless a line end acts
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run_en && !line_end) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R6: a line end restarts the count and keeps the phase
  assert_line_end_R6: assert property (@(posedge clk) disable iff (rst)
    (run_en && line_end) |=> (cnt_q == '0) && (phase_q == $past(phase_q)));

  // R8: the wrap strobe only appears at count zero
  assert_wrap_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> (cnt_q == '0));

  // R7: the three decoded outputs are mutually exclusive
  assert_decode_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({hsync_q, fetch_q, border_q}) <= 1);

endmodule

// File: rtl/htiming_seq.sv
module htiming_seq
  import htiming_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int NUM_P  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [CNT_W-1:0]  hcount,
  output logic [2:0]        phase,
  output logic              hsync,
  output logic              fetch_en,
  output logic              border_sel,
  output logic              line_wrap,
  output logic [2:0]        pix_format,
  output logic [8:0]        burst_bytes
);

  localparam int IDX_W = $clog2(NUM_P);

  logic [NUM_P-1:0][CNT_W-1:0] eff;
  logic [CNT_W-1:0]            cnt;
  logic                        run_en, ph_valid, line_end;
  logic [IDX_W-1:0]            ph_idx;
  logic [1:0]                  burst_code;
  phase_e                      phase_st;

  htiming_regs #(.CNT_W(CNT_W), .NUM_P(NUM_P), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cnt(cnt), .eff(eff), .run_en(run_en),
    .fmt(pix_format), .burst(burst_code)
  );

  htiming_match #(.CNT_W(CNT_W), .NUM_P(NUM_P), .IDX_W(IDX_W)) match_i (
    .clk(clk), .rst(rst), .cnt(cnt), .eff(eff),
    .ph_valid(ph_valid), .ph_idx(ph_idx), .line_end(line_end)
  );

  htiming_phase #(.CNT_W(CNT_W), .IDX_W(IDX_W)) phase_i (
    .clk(clk), .rst(rst), .run_en(run_en), .ph_valid(ph_valid),
    .ph_idx(ph_idx), .line_end(line_end), .cnt(cnt), .phase(phase_st),
    .hsync(hsync), .fetch_en(fetch_en), .border_sel(border_sel),
    .line_wrap(line_wrap)
  );

  assign hcount      = cnt;
  assign phase       = phase_st;
  assign burst_bytes = burst_to_bytes(burst_code);

endmodule

// File: tb/htiming_seq_tb_top.sv
`timescale 1ns/1ps
module htiming_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] hcount;
  logic [2:0]  phase;
  logic        hsync, fetch_en, border_sel, line_wrap;
  logic [2:0]  pix_format;
  logic [8:0]  burst_bytes;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  htiming_seq dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hcount(hcount),
    .phase(phase), .hsync(hsync), .fetch_en(fetch_en),
    .border_sel(border_sel), .line_wrap(line_wrap),
    .pix_format(pix_format), .burst_bytes(burst_bytes)
  );

  typedef struct packed {
    logic [11:0] hc;
    logic [2:0]  ph;
    logic        hs, fe, bs, lw;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements; steps on its own copies
  logic [11:0] m_live [8];
  logic [11:0] m_sh   [8];
  logic [11:0] m_cnt;
  logic [2:0]  m_ph;
  logic        m_en, m_wrap;

  always @(posedge clk) begin
    logic [11:0] eff [8];
    logic [11:0] nc;
    int win;
    int k;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_live[i] = '0; m_sh[i] = '0; end
      m_cnt = '0; m_ph = 3'd6; m_en = 1'b0; m_wrap = 1'b0;
    end else begin
      for (int i = 0; i < 8; i++) eff[i] = (m_cnt == 0) ? m_live[i] : m_sh[i];
      if (m_cnt == 0) for (int i = 0; i < 8; i++) m_sh[i] = m_live[i];
      if (!m_en) begin
        m_cnt = '0; m_ph = 3'd6; m_wrap = 1'b0;
      end else begin
        win = -1;
        for (int i = 0; i < 8; i++)
          if (eff[i] == m_cnt && !(i == 7 && eff[7] == 0)) win = i;
        nc = (win == 7) ? 12'd0 : m_cnt + 12'd1;
        if (win >= 0 && win < 7) m_ph = 3'(win);
        m_cnt  = nc;
        m_wrap = (nc == 0);
      end
      if (reg_we) begin
        if (reg_addr == 8'h00) m_en = reg_wdata[16];
        else if (reg_addr >= 8'h04 && reg_addr <= 8'h10 && reg_addr[1:0] == 2'b00) begin
          k = int'(reg_addr >> 2) - 1;
          m_live[2*k]   = reg_wdata[11:0];
          m_live[2*k+1] = reg_wdata[27:16];
        end
      end
      exp_q.push_back('{hc: m_cnt, ph: m_ph, hs: (m_ph == 3'd0), fe: (m_ph == 3'd3),
                        bs: (m_ph == 3'd2 || m_ph == 3'd4), lw: m_wrap});
    end
  end

  // Monitor: pops one expected item per cycle and compares the ports
  always @(negedge clk) begin
    exp_t e;
    if (!rst && !done && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check("R2", "hcount",     32'(hcount),     32'(e.hc));
      check("R4", "phase",      32'(phase),      32'(e.ph));
      check("R7", "hsync",      32'(hsync),      32'(e.hs));
      check("R7", "fetch_en",   32'(fetch_en),   32'(e.fe));
      check("R7", "border_sel", 32'(border_sel), 32'(e.bs));
      check("R8", "line_wrap",  32'(line_wrap),  32'(e.lw));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(req, "readback", reg_rdata, exp);
  endtask

  task automatic wait_hc(input logic [11:0] v);
    do @(negedge clk); while (hcount !== v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "phase",    32'(phase), 32'd6);
    check("R1", "hcount",   32'(hcount), 32'd0);
    check("R1", "outputs",  32'({hsync, fetch_en, border_sel, line_wrap}), 32'd0);
    rd_check("R1", 8'h00, 32'h0);
    rd_check("R1", 8'h10, 32'h0);
    // R3 field widths and padding
    wr(8'h04, 32'hFFFF_FFFF);
    rd_check("R3", 8'h04, 32'h0FFF_0FFF);
    // R10 configuration padding, R11 burst decode (block idle, shadow follows)
    wr(8'h00, 32'hFFFE_FFFF);
    rd_check("R10", 8'h00, 32'h0000_0307);
    check("R11", "burst_bytes", 32'(burst_bytes), 32'd256);
    check("R11", "pix_format",  32'(pix_format),  32'd7);
    wr(8'h00, 32'h0000_0105);
    repeat (2) @(negedge clk);
    check("R11", "burst_bytes", 32'(burst_bytes), 32'd128);
    wr(8'h00, 32'h0000_0004);
    repeat (2) @(negedge clk);
    check("R11", "burst_bytes", 32'(burst_bytes), 32'd64);
    // Program a line: P1..P8 = 2,6,10,14,30,34,38,40
    wr(8'h04, 32'h0006_0002);
    wr(8'h08, 32'h000E_000A);
    wr(8'h0C, 32'h0022_001E);
    wr(8'h10, 32'h0028_0026);
    rd_check("R3", 8'h0C, 32'h0022_001E);
    wr(8'h00, 32'h0001_0200);
    wait_hc(12'd3);
    check("R7", "hsync in sync", 32'(hsync), 32'd1);
    wait_hc(12'd11);
    check("R4", "left border", 32'(phase), 32'd2);
    check("R7", "border_sel", 32'(border_sel), 32'd1);
    wait_hc(12'd15);
    check("R4", "image", 32'(phase), 32'd3);
    check("R7", "fetch_en", 32'(fetch_en), 32'd1);
    wait_hc(12'd40);
    @(negedge clk);
    check("R6", "restart", 32'(hcount), 32'd0);
    check("R8", "wrap pulse", 32'(line_wrap), 32'd1);
    // R9: mid-line write of P5 only acts from the next line
    wait_hc(12'd12);
    wr(8'h0C, 32'h0022_0012);
    wait_hc(12'd19);
    check("R9", "old P5 this line", 32'(phase), 32'd3);
    wait_hc(12'd0);
    wait_hc(12'd19);
    check("R9", "new P5 next line", 32'(phase), 32'd4);
    // R5: P1=P2=6 and P7=P8=40
    wr(8'h04, 32'h0006_0006);
    wr(8'h10, 32'h0028_0028);
    wait_hc(12'd0);
    wait_hc(12'd1);
    wait_hc(12'd7);
    check("R5", "P2 beats P1", 32'(phase), 32'd1);
    check("R5", "no hsync", 32'(hsync), 32'd0);
    wait_hc(12'd40);
    @(negedge clk);
    check("R5", "P8 beats P7", 32'(phase), 32'd5);
    check("R6", "restart", 32'(hcount), 32'd0);
    // R2: disable holds idle
    wr(8'h00, 32'h0);
    repeat (2) @(negedge clk);
    check("R2", "idle hcount", 32'(hcount), 32'd0);
    check("R2", "idle phase",  32'(phase),  32'd6);
    // R2/R8: P8 = 0 gives the natural wrap
    wr(8'h10, 32'h0000_0026);
    wr(8'h00, 32'h0001_0000);
    wait_hc(12'd41);
    check("R2", "past old line end", 32'(hcount), 32'd41);
    wait_hc(12'd4095);
    @(negedge clk);
    check("R2", "natural wrap", 32'(hcount), 32'd0);
    check("R8", "wrap pulse", 32'(line_wrap), 32'd1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule